// File: doc/BRIEF.md
# ATA Task-File Address Router

This block sits between a removable-card host interface and a disk controller model. A host access arrives with a byte address, a 16-bit write word and a read or write strobe. The router turns the address into a 4-bit task-file offset. How it does that depends on a 2-bit decode mode that the card's option register supplies. In memory mode a 1 KiB data window is folded onto the data port. In the contiguous I/O mode only the low address nibble counts. The two legacy I/O modes each accept a command window and a control window at fixed addresses.

Once it has the offset, the router steers the access. Data-port, error/feature and plain task-register accesses go to a single-cycle register port toward the controller. The router answers the remaining offsets itself. It holds the device-control byte and raises a soft-reset pulse. It keeps a byte latch and a byte-phase flag for the odd data offset. It builds the device-address byte. It also produces the wake-up signal that ends power-down when an ordinary task register is written. Read data reaches the host in the same cycle as the read strobe.

Top module: `tfr_addr_router`

## Requirements
- R1: Mode 0 (memory): any address in 0x400–0x7FF maps to offset 0 (data). An address below 0x010 maps to itself. Every other address matches nothing.
- R2: Mode 1 (contiguous I/O): every address matches, and the offset is address bits [3:0].
- R3: Mode 2 (primary I/O): 0x1F0–0x1FF maps to address−0x1F0. 0x3F0–0x3F7 maps to address−0x3E8, which gives offsets 8–15. All other addresses, including 0x3F8–0x3FF, match nothing.
- R4: Mode 3 (secondary I/O): 0x170–0x17F maps to address−0x170. 0x370–0x377 maps to address−0x368. All other addresses match nothing.
- R5: Offsets 0 and 8 pass the access to downstream index 0 with the full 16-bit word. Read data is dev_rdata, returned in the same cycle.
- R6: Offset 13 passes reads and writes to downstream index 1 (error on read, feature on write).
- R7: A read of offset 14 returns {8'h00, drv_status} when drv_present is 1, and 0 otherwise. It makes no downstream access.
- R8: A write of offset 14 loads dctl_q with wdata[7:0] on the next clock. When wdata bit 2 is set, soft_rst is high for exactly the next cycle, and byte_phase and the byte latch are cleared.
- R9: A read of offset 15 returns 0x00FE when drv_select is 0 and 0x00FA when drv_select is 1. It makes no downstream access.
- R10: A write to a plain task offset (1–7, 10–12 or 15) goes to downstream index offset[2:0]. If pwrdn_flag is high during that write, wake is high in the same cycle. Writes to offsets 0, 8, 9, 13 and 14 never raise wake.
- R11: A data read (offset 0 or 8) stores dev_rdata in the byte latch. A read of offset 9 returns {8'h00, latch[15:8]}. A write of offset 9 stores {8'h00, wdata[7:0]} in the latch and toggles byte_phase.
- R12: An access that matches nothing produces no downstream strobe, no wake and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Decode mode: 0 memory, 1 contiguous I/O, 2 primary I/O, 3 secondary I/O |
| host_addr | input | 11 | Host byte address |
| host_wdata | input | 16 | Host write word |
| host_rd | input | 1 | Host read strobe (ignored while host_wr is high) |
| host_wr | input | 1 | Host write strobe |
| host_rdata | output | 16 | Read data, same cycle as host_rd |
| dev_addr | output | 3 | Downstream task register index |
| dev_wdata | output | 16 | Downstream write word |
| dev_rd | output | 1 | Downstream single-cycle read strobe |
| dev_wr | output | 1 | Downstream single-cycle write strobe |
| dev_rdata | input | 16 | Downstream read word |
| drv_status | input | 8 | Drive status byte |
| drv_present | input | 1 | A drive is attached |
| drv_select | input | 1 | Currently selected drive |
| pwrdn_flag | input | 1 | Power-down status bit of the card |
| wake | output | 1 | Raise card-ready and clear power-down |
| dctl_q | output | 8 | Device-control byte |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| byte_phase | output | 1 | Odd-byte phase flag |

## Verification
A vector table sweeps every decode mode with addresses in each window, at window edges (0x400, 0x7FF, 0x3F7 against 0x3F8) and just outside them. A folded data address and a miss would look alike if only the read data were checked, so each vector compares the strobe, the index and the read data together. Mixing command-window and control-window hits in the same mode exposes a wrong subtraction constant, because offsets 8–15 land on different registers than 0–7. Directed cases cover:
- the local registers;
- the wake rule, with writes to special offsets while power-down is set;
- the byte latch, through the sequence data read, odd read, odd write, soft reset.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
   typedef enum logic [1:0] {
      TFR_MEM  = 2'd0,
      TFR_IO16 = 2'd1,
      TFR_PRI  = 2'd2,
      TFR_SEC  = 2'd3
   } tfr_mode_e;

   typedef enum logic [2:0] {
      K_DATA, K_ODD, K_ERRF, K_CTL, K_DADR, K_TASK
   } tfr_kind_e;

   localparam logic [3:0] OFF_DATA  = 4'h0;
   localparam logic [3:0] OFF_DATA2 = 4'h8;
   localparam logic [3:0] OFF_ODD   = 4'h9;
   localparam logic [3:0] OFF_ERRF  = 4'hD;
   localparam logic [3:0] OFF_CTL   = 4'hE;
   localparam logic [3:0] OFF_DADR  = 4'hF;

   function automatic tfr_kind_e tfr_classify(input logic [3:0] off);
      case (off)
         OFF_DATA, OFF_DATA2: tfr_classify = K_DATA;
         OFF_ODD:             tfr_classify = K_ODD;
         OFF_ERRF:            tfr_classify = K_ERRF;
         OFF_CTL:             tfr_classify = K_CTL;
         OFF_DADR:            tfr_classify = K_DADR;
         default:             tfr_classify = K_TASK;
      endcase
   endfunction
endpackage

// File: rtl/tfr_addr_map.sv
module tfr_addr_map
   import tfr_pkg::*;
#(
   parameter int AW = 11,
   parameter logic [AW-1:0] PRI_CMD = 11'h1F0,
   parameter logic [AW-1:0] PRI_CTL = 11'h3F0,
   parameter logic [AW-1:0] SEC_CMD = 11'h170,
   parameter logic [AW-1:0] SEC_CTL = 11'h370
) (
   input  logic          clk,
   input  logic          rst_n,
   input  tfr_mode_e     mode,
   input  logic [AW-1:0] addr,
   output logic          hit,
   output logic [3:0]    off
);
   localparam int HW = AW - 4;
   localparam int MW = AW - 10;
   localparam logic [AW-1:0] CMD_BASE [2] = '{PRI_CMD, SEC_CMD};
   localparam logic [AW-1:0] CTL_BASE [2] = '{PRI_CTL, SEC_CTL};

   if (AW < 11) begin : g_bad_aw
      $error("tfr_addr_map: AW must be at least 11");
   end

   logic [1:0] cmd_hit, ctl_hit;

   for (genvar w = 0; w < 2; w++) begin : g_win
      assign cmd_hit[w] = (addr[AW-1:4] == CMD_BASE[w][AW-1:4]);
      // the control window lands at offsets 8..15: only its lower half is valid
      assign ctl_hit[w] = (addr[AW-1:4] == CTL_BASE[w][AW-1:4]) && !addr[3];
   end

   always_comb begin
      hit = 1'b0;
      off = addr[3:0];
      case (mode)
         TFR_MEM: begin
            if (addr[AW-1:10] == MW'(1)) begin
               hit = 1'b1;
               off = OFF_DATA;
            end else if (addr[AW-1:4] == HW'(0)) begin
               hit = 1'b1;
            end
         end
         TFR_IO16: hit = 1'b1;
         TFR_PRI, TFR_SEC: begin
            if (cmd_hit[mode[0]]) begin
               hit = 1'b1;
            end else if (ctl_hit[mode[0]]) begin
               hit = 1'b1;
               off = {1'b1, addr[2:0]};
            end
         end
         default: hit = 1'b0;
      endcase
   end

   // R2
   io16_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TFR_IO16) |-> (hit && off == addr[3:0]));
endmodule

// File: rtl/tfr_reg_steer.sv
module tfr_reg_steer
   import tfr_pkg::*;
#(
   parameter int DW = 16,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit,
   input  logic [3:0]    off,
   input  logic          host_rd,
   input  logic          host_wr,
   input  logic [DW-1:0] dev_rdata,
   input  logic [7:0]    drv_status,
   input  logic          drv_present,
   input  logic          drv_select,
   input  logic          pwrdn_flag,
   input  logic [7:0]    latch_hi,
   output logic [DW-1:0] host_rdata,
   output logic [IW-1:0] dev_addr,
   output logic          dev_rd,
   output logic          dev_wr,
   output logic          wake,
   output logic          dctl_we,
   output logic          odd_we,
   output logic          data_rd
);
   localparam logic [IW-1:0] IDX_DATA = IW'(0);
   localparam logic [IW-1:0] IDX_ERRF = IW'(1);

   if (IW != 3) begin : g_bad_iw
      $error("tfr_reg_steer: task index must be 3 bits");
   end

   tfr_kind_e kind;
   logic      rd_q, wr_q;

   assign kind = tfr_classify(off);
   assign wr_q = hit && host_wr;
   assign rd_q = hit && host_rd && !host_wr;

   always_comb begin
      host_rdata = '0;
      dev_addr   = off[IW-1:0];
      dev_rd     = 1'b0;
      dev_wr     = 1'b0;
      wake       = 1'b0;
      dctl_we    = 1'b0;
      odd_we     = 1'b0;
      data_rd    = 1'b0;
      case (kind)
         K_DATA: begin
            dev_addr = IDX_DATA;
            dev_rd   = rd_q;
            dev_wr   = wr_q;
            data_rd  = rd_q;
            if (rd_q) host_rdata = dev_rdata;
         end
         K_ODD: begin
            odd_we = wr_q;
            if (rd_q) host_rdata = DW'(latch_hi);
         end
         K_ERRF: begin
            dev_addr = IDX_ERRF;
            dev_rd   = rd_q;
            dev_wr   = wr_q;
            if (rd_q) host_rdata = dev_rdata;
         end
         K_CTL: begin
            dctl_we = wr_q;
            if (rd_q && drv_present) host_rdata = DW'(drv_status);
         end
         K_DADR: begin
            // reads are answered locally, writes fall through to the task file
            dev_wr = wr_q;
            wake   = wr_q && pwrdn_flag;
            if (rd_q) host_rdata = DW'({5'b11111, ~drv_select, 2'b10});
         end
         default: begin
            dev_rd = rd_q;
            dev_wr = wr_q;
            wake   = wr_q && pwrdn_flag;
            if (rd_q) host_rdata = dev_rdata;
         end
      endcase
   end

   // R10
   wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (dev_wr && pwrdn_flag && host_wr));
   // R12
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (!dev_rd && !dev_wr && !wake && host_rdata == '0));
   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_rd && dev_wr));
endmodule

// File: rtl/tfr_ctl_regs.sv
module tfr_ctl_regs #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dctl_we,
   input  logic          odd_we,
   input  logic          data_rd,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] dev_rdata,
   output logic [7:0]    dctl_q,
   output logic          soft_rst,
   output logic          byte_phase,
   output logic [7:0]    latch_hi
);
   localparam int SRST_BIT = 2;

   if (DW != 16) begin : g_bad_dw
      $error("tfr_ctl_regs: data width must be 16");
   end

   logic [DW-1:0] latch_q;
   logic          srst_req;

   assign srst_req = dctl_we && wdata[SRST_BIT];
   assign latch_hi = latch_q[DW-1:DW-8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dctl_q     <= '0;
         soft_rst   <= 1'b0;
         byte_phase <= 1'b0;
         latch_q    <= '0;
      end else begin
         soft_rst <= srst_req;
         if (dctl_we) dctl_q <= wdata[7:0];
         if (srst_req) begin
            byte_phase <= 1'b0;
            latch_q    <= '0;
         end else if (odd_we) begin
            byte_phase <= ~byte_phase;
            latch_q    <= {8'h00, wdata[7:0]};
         end else if (data_rd) begin
            latch_q    <= dev_rdata;
         end
      end
   end

   // R8
   srst_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> ($past(dctl_we) && $past(wdata[SRST_BIT])));
   // R8
   dctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(dctl_we) |-> $stable(dctl_q));
   // R11
   phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(odd_we) && !$past(dctl_we)) |-> (byte_phase != $past(byte_phase)));
endmodule

// File: rtl/tfr_addr_router.sv
module tfr_addr_router
   import tfr_pkg::*;
#(
   parameter int AW = 11,
   parameter int DW = 16,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_sel,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   input  logic          host_rd,
   input  logic          host_wr,
   output logic [DW-1:0] host_rdata,
   output logic [IW-1:0] dev_addr,
   output logic [DW-1:0] dev_wdata,
   output logic          dev_rd,
   output logic          dev_wr,
   input  logic [DW-1:0] dev_rdata,
   input  logic [7:0]    drv_status,
   input  logic          drv_present,
   input  logic          drv_select,
   input  logic          pwrdn_flag,
   output logic          wake,
   output logic [7:0]    dctl_q,
   output logic          soft_rst,
   output logic          byte_phase
);
   logic       hit, dctl_we, odd_we, data_rd;
   logic [3:0] off;
   logic [7:0] latch_hi;

   assign dev_wdata = host_wdata;

   tfr_addr_map #(.AW(AW)) u_map (
      .clk(clk), .rst_n(rst_n), .mode(tfr_mode_e'(mode_sel)),
      .addr(host_addr), .hit(hit), .off(off)
   );

   tfr_reg_steer #(.DW(DW), .IW(IW)) u_steer (
      .clk(clk), .rst_n(rst_n), .hit(hit), .off(off),
      .host_rd(host_rd), .host_wr(host_wr), .dev_rdata(dev_rdata),
      .drv_status(drv_status), .drv_present(drv_present),
      .drv_select(drv_select), .pwrdn_flag(pwrdn_flag), .latch_hi(latch_hi),
      .host_rdata(host_rdata), .dev_addr(dev_addr), .dev_rd(dev_rd),
      .dev_wr(dev_wr), .wake(wake), .dctl_we(dctl_we), .odd_we(odd_we),
      .data_rd(data_rd)
   );

   tfr_ctl_regs #(.DW(DW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .dctl_we(dctl_we), .odd_we(odd_we),
      .data_rd(data_rd), .wdata(host_wdata), .dev_rdata(dev_rdata),
      .dctl_q(dctl_q), .soft_rst(soft_rst), .byte_phase(byte_phase),
      .latch_hi(latch_hi)
   );

   // R6
   errf_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && mode_sel == 2'd1 && host_addr[3:0] == 4'hD) |-> (dev_wr && dev_addr == IW'(1)));
endmodule

// File: tb/tfr_addr_router_tb.sv
`timescale 1ns/1ps
module tfr_addr_router_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_sel = '0;
   logic [10:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic        host_rd = 1'b0, host_wr = 1'b0;
   logic [15:0] host_rdata, dev_wdata, dev_rdata;
   logic [2:0]  dev_addr;
   logic        dev_rd, dev_wr, wake, soft_rst, byte_phase;
   logic [7:0]  drv_status = 8'h50, dctl_q;
   logic        drv_present = 1'b1, drv_select = 1'b0, pwrdn_flag = 1'b0;
   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   // downstream model: word carries its own index
   assign dev_rdata = {8'h5A, 5'b0, dev_addr};

   tfr_addr_router u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rd(host_rd), .host_wr(host_wr),
      .host_rdata(host_rdata), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
      .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_rdata(dev_rdata),
      .drv_status(drv_status), .drv_present(drv_present),
      .drv_select(drv_select), .pwrdn_flag(pwrdn_flag), .wake(wake),
      .dctl_q(dctl_q), .soft_rst(soft_rst), .byte_phase(byte_phase)
   );

   // {mode, addr, is_write, expect_hit, expect_index}
   localparam int NV = 19;
   localparam logic [17:0] VEC [NV] = '{
      {2'd0, 11'h400, 1'b0, 1'b1, 3'd0},
      {2'd0, 11'h7FF, 1'b1, 1'b1, 3'd0},
      {2'd0, 11'h003, 1'b0, 1'b1, 3'd3},
      {2'd0, 11'h00D, 1'b0, 1'b1, 3'd1},
      {2'd0, 11'h010, 1'b0, 1'b0, 3'd0},
      {2'd0, 11'h008, 1'b1, 1'b1, 3'd0},
      {2'd1, 11'h3F5, 1'b0, 1'b1, 3'd5},
      {2'd1, 11'h1F2, 1'b1, 1'b1, 3'd2},
      {2'd1, 11'h7D8, 1'b0, 1'b1, 3'd0},
      {2'd1, 11'h00D, 1'b1, 1'b1, 3'd1},
      {2'd2, 11'h1F7, 1'b1, 1'b1, 3'd7},
      {2'd2, 11'h3F5, 1'b0, 1'b1, 3'd1},
      {2'd2, 11'h1F0, 1'b0, 1'b1, 3'd0},
      {2'd2, 11'h170, 1'b0, 1'b0, 3'd0},
      {2'd2, 11'h3F8, 1'b0, 1'b0, 3'd0},
      {2'd3, 11'h175, 1'b1, 1'b1, 3'd5},
      {2'd3, 11'h375, 1'b0, 1'b1, 3'd1},
      {2'd3, 11'h1F3, 1'b0, 1'b0, 3'd0},
      {2'd3, 11'h17C, 1'b1, 1'b1, 3'd4}
   };

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic [1:0] m, input logic [10:0] a, input bit wr, input logic [15:0] wd);
      @(negedge clk);
      mode_sel = m; host_addr = a; host_wdata = wd;
      host_wr = wr; host_rd = !wr;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      host_rd = 1'b0; host_wr = 1'b0;
      #1;
   endtask

   function automatic string mode_req(input logic [1:0] m);
      case (m)
         2'd0: return "R1";
         2'd1: return "R2";
         2'd2: return "R3";
         default: return "R4";
      endcase
   endfunction

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // reset state (R8 R11)
      chk(dctl_q == 8'h00 && !soft_rst, "R8 reset", {8'h0, dctl_q}, 16'h0);
      chk(!byte_phase, "R11 reset", {15'h0, byte_phase}, 16'h0);

      for (int i = 0; i < NV; i++) begin
         logic [1:0]  m;
         logic [10:0] a;
         logic        w, h;
         logic [2:0]  x;
         {m, a, w, h, x} = VEC[i];
         acc(m, a, w, 16'h1234);
         if (w) begin
            chk(dev_wr == h && !dev_rd && !wake, {mode_req(m), " R12 wr strobe"}, {14'h0, dev_wr, dev_rd}, {14'h0, h, 1'b0});
            if (h) chk(dev_addr == x && dev_wdata == 16'h1234, {mode_req(m), " R5 R6 wr index"}, {13'h0, dev_addr}, {13'h0, x});
         end else begin
            chk(dev_rd == h && !dev_wr, {mode_req(m), " R12 rd strobe"}, {14'h0, dev_wr, dev_rd}, {15'h0, h});
            chk(host_rdata == (h ? {8'h5A, 5'b0, x} : 16'h0), {mode_req(m), " R5 R6 rd data"}, host_rdata, h ? {8'h5A, 5'b0, x} : 16'h0);
         end
         idle();
      end

      // R7 status read
      acc(2'd1, 11'h00E, 1'b0, 16'h0);
      chk(host_rdata == 16'h0050 && !dev_rd, "R7 present", host_rdata, 16'h0050);
      drv_present = 1'b0; #1;
      chk(host_rdata == 16'h0000, "R7 absent", host_rdata, 16'h0000);
      drv_present = 1'b1;
      idle();

      // R9 device address
      acc(2'd2, 11'h3F7, 1'b0, 16'h0);
      chk(host_rdata == 16'h00FE && !dev_rd, "R9 sel0", host_rdata, 16'h00FE);
      drv_select = 1'b1; #1;
      chk(host_rdata == 16'h00FA, "R9 sel1", host_rdata, 16'h00FA);
      drv_select = 1'b0;
      idle();

      // R10 wake
      pwrdn_flag = 1'b1;
      acc(2'd1, 11'h003, 1'b1, 16'h0077);
      chk(wake && dev_wr && dev_addr == 3'd3, "R10 task write wakes", {15'h0, wake}, 16'h1);
      idle();
      acc(2'd1, 11'h00D, 1'b1, 16'h0077);
      chk(!wake && dev_wr, "R10 feature no wake", {15'h0, wake}, 16'h0);
      idle();
      acc(2'd1, 11'h000, 1'b1, 16'h0077);
      chk(!wake, "R10 data no wake", {15'h0, wake}, 16'h0);
      idle();
      acc(2'd1, 11'h00E, 1'b1, 16'h0002);
      chk(!wake && !dev_wr, "R10 ctl no wake", {15'h0, wake}, 16'h0);
      idle();
      chk(dctl_q == 8'h02 && !soft_rst, "R8 dctl load", {8'h0, dctl_q}, 16'h0002);
      pwrdn_flag = 1'b0;

      // R11 byte latch
      acc(2'd1, 11'h000, 1'b0, 16'h0);
      idle();
      acc(2'd1, 11'h009, 1'b0, 16'h0);
      chk(host_rdata == 16'h005A && !dev_rd, "R11 odd read", host_rdata, 16'h005A);
      idle();
      acc(2'd1, 11'h009, 1'b1, 16'hBEC3);
      chk(!dev_wr, "R11 odd write local", {15'h0, dev_wr}, 16'h0);
      idle();
      chk(byte_phase, "R11 phase toggled", {15'h0, byte_phase}, 16'h1);
      acc(2'd1, 11'h009, 1'b0, 16'h0);
      chk(host_rdata == 16'h0000, "R11 latch low only", host_rdata, 16'h0000);
      idle();

      // R8 soft reset
      acc(2'd1, 11'h00E, 1'b1, 16'h0006);
      idle();
      chk(soft_rst && dctl_q == 8'h06, "R8 srst pulse", {7'h0, soft_rst, dctl_q}, 16'h0106);
      chk(!byte_phase, "R8 phase cleared", {15'h0, byte_phase}, 16'h0);
      idle();
      chk(!soft_rst, "R8 pulse one cycle", {15'h0, soft_rst}, 16'h0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule